// File: doc/BRIEF.md
# Protected Setting Store with Timed Commit

This block keeps the settings of an adjustable reference: an 8-bit wiper code and an 8-bit spare register. Each is backed by storage that survives power loss, modelled here as shadow flops that take parameter values on the first reset. A volatile status word holds one write-enable bit. Both stored registers refuse new data unless that bit is set. A serial slave in front of the block presents an address, data and a write strobe for each byte. It also pulses a stop input when the command ends.

An accepted write is held as pending until the stop arrives. It is then committed by a self-timed write cycle, and the busy output is high for that whole cycle. While busy is high, the block ignores the bus and reads return zero. When supply-good rises, a recall counter runs for a fixed time and then loads the stored wiper code into the active wiper output. Until then the output sits at midscale (80h). While the brownout input is high the output is also held at midscale, and it returns to the stored code once the brownout ends.

Top module: `nvr_ctrl`

## Requirements
- R1: After reset, `wiper` is 80h, `busy` is 0 and a read of the status address (7h) returns 00h.
- R2: The status register at address 7h has one writable bit, bit 3, the write-enable bit. A strobe sets that bit from `wr_data[3]` at the next clock edge. A read of 7h returns the bit at position 3 and 0 in every other bit. The bit keeps its value across write cycles.
- R3: A write to address 0h (wiper) or 1h (spare) while the write-enable bit is 0 is dropped. A following stop does not raise `busy`, and neither the register contents nor `wiper` change.
- R4: A stop that ends a command holding an accepted write raises `busy` at the next clock edge. `busy` then stays high for exactly WR_CYCLES clock cycles.
- R5: The committed value appears on the read port at the edge where `busy` falls. For address 0h it appears on `wiper` at that same edge.
- R6: While `busy` is high, reads return 00h. Write strobes and stops are ignored, including writes to the status register.
- R7: When several data writes come before one stop, only the last one is committed. A stop with no accepted write pending does nothing.
- R8: After `pwr_good` rises, `wiper` holds 80h until RECALL_CYC rising edges have sampled `pwr_good` high. From that edge on, `wiper` shows the stored wiper code. Bus writes are ignored until the recall is complete.
- R9: Each edge that samples `brown_out` high drives `wiper` to 80h. The first edge that samples it low again reloads `wiper` from the stored code. A write cycle that commits during a brownout updates the stored value, and only that stored value.
- R10: An edge that samples `pwr_good` low clears the write-enable bit, ends any write cycle without committing it, and drives `wiper` to 80h.
- R11: Addresses other than 0h, 1h and 7h read 00h. Writes to them start no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loads the stored registers with their initial values |
| pwr_good | input | 1 | Supply is up; low means power loss |
| brown_out | input | 1 | Supply is below the brownout threshold |
| reg_addr | input | AW | Register address for reads and writes |
| wr_data | input | DW | Data byte for a write |
| wr_stb | input | 1 | One-cycle write strobe |
| cmd_stop | input | 1 | One-cycle pulse at the end of a bus command |
| rd_data | output | DW | Combinational read data for `reg_addr` |
| busy | output | 1 | Write cycle in progress |
| wiper | output | DW | Active wiper code |

## Verification
A strobe or stop driven before edge k takes effect at edge k. The write-enable bit, the pending write and `busy` can therefore be seen at the falling edge that follows. `rd_data` is combinational, so it is sampled one nanosecond after the address is set. The bench counts the falling edges at which `busy` is high. That count must equal WR_CYCLES, and the committed value and `wiper` are checked at the first falling edge with `busy` low. For recall, `wiper` is sampled at the falling edge just before edge RECALL_CYC, where it must still be 80h, and again just after that edge, where it must show the stored code. Brownout entry and exit are both checked one falling edge after the input changes.

// File: rtl/nvr_pkg.sv
package nvr_pkg;
   localparam int unsigned REG_WIPER = 0;
   localparam int unsigned REG_GP    = 1;
   localparam int unsigned REG_STAT  = 7;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_WIPER = 2'd1,
      SEL_GP    = 2'd2
   } nv_sel_e;
endpackage

// File: rtl/nvr_recall.sv
module nvr_recall #(
   parameter int unsigned RECALL_CYC = 250_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   output logic done,
   output logic fire
);
   localparam int unsigned CW = $clog2(RECALL_CYC + 1);

   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign fire = pwr_good && !done_q && (cnt_q == CW'(RECALL_CYC - 1));
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!pwr_good) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (fire) done_q <= 1'b1;
         else      cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/nvr_status.sv
module nvr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic bus_ok,
   input  logic wr_stb,
   input  logic is_stat,
   input  logic wel_in,
   output logic wel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wel <= 1'b0;
      else if (!pwr_good)                      wel <= 1'b0;
      else if (bus_ok && wr_stb && is_stat)    wel <= wel_in;
   end
endmodule

// File: rtl/nvr_wcycle.sv
module nvr_wcycle
   import nvr_pkg::*;
#(
   parameter int unsigned DW        = 8,
   parameter int unsigned WR_CYCLES = 2_500_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_good,
   input  logic          bus_ok,
   input  logic          wr_stb,
   input  logic          cmd_stop,
   input  logic          wel,
   input  nv_sel_e       sel,
   input  logic [DW-1:0] wr_data,
   output logic          busy,
   output logic          commit,
   output nv_sel_e       commit_sel,
   output logic [DW-1:0] commit_data
);
   logic    pend_vld;
   nv_sel_e pend_sel;
   logic [DW-1:0] pend_data;
   logic    start;
   logic    done_tick;

   assign start = bus_ok && cmd_stop && pend_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_sel  <= SEL_NONE;
         pend_data <= '0;
      end else if (!pwr_good) begin
         pend_vld  <= 1'b0;
      end else if (bus_ok && cmd_stop) begin
         pend_vld  <= 1'b0;
      end else if (bus_ok && wr_stb && wel && (sel != SEL_NONE)) begin
         pend_vld  <= 1'b1;
         pend_sel  <= sel;
         pend_data <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= 1'b0;
      else if (!pwr_good)  busy <= 1'b0;
      else if (start)      busy <= 1'b1;
      else if (done_tick)  busy <= 1'b0;
   end

   generate
      if (WR_CYCLES == 1) begin : g_single
         assign done_tick = busy;
      end else begin : g_count
         localparam int unsigned CW = $clog2(WR_CYCLES);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (start)                 cnt_q <= CW'(WR_CYCLES - 1);
            else if (busy && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign done_tick = busy && (cnt_q == '0);
      end
   endgenerate

   assign commit      = done_tick && pwr_good;
   assign commit_sel  = pend_sel;
   assign commit_data = pend_data;
endmodule

// File: rtl/nvr_ctrl.sv
module nvr_ctrl
   import nvr_pkg::*;
#(
   parameter int unsigned DW            = 8,
   parameter int unsigned AW            = 3,
   parameter int unsigned WEL_BIT       = 3,
   parameter int unsigned WR_CYCLES     = 2_500_000,
   parameter int unsigned RECALL_CYC    = 250_000,
   parameter int unsigned NV_WIPER_INIT = 'h80,
   parameter int unsigned NV_GP_INIT    = 'h00,
   parameter bit          BUSY_RD_ZERO  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_good,
   input  logic          brown_out,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_stb,
   input  logic          cmd_stop,
   output logic [DW-1:0] rd_data,
   output logic          busy,
   output logic [DW-1:0] wiper
);
   localparam logic [DW-1:0] MIDSCALE = {1'b1, {(DW-1){1'b0}}};

   generate
      if (DW < 4)                    begin : g_bad_dw   $error("DW too small"); end
      if (WEL_BIT >= DW)             begin : g_bad_wel  $error("WEL_BIT out of range"); end
      if (AW < 3)                    begin : g_bad_aw   $error("AW must reach address 7"); end
      if (WR_CYCLES < 1)             begin : g_bad_wc   $error("WR_CYCLES must be >= 1"); end
      if (RECALL_CYC < 1)            begin : g_bad_rc   $error("RECALL_CYC must be >= 1"); end
   endgenerate

   nv_sel_e       addr_sel;
   logic          is_stat;
   logic          recall_done, recall_fire;
   logic          bus_ok;
   logic          wel_q;
   logic          commit;
   nv_sel_e       commit_sel;
   logic [DW-1:0] commit_data;
   logic [DW-1:0] nv_wip_q, nv_gp_q, nv_wip_nxt;
   logic [DW-1:0] wiper_q;
   logic [DW-1:0] rd_raw;
   logic [DW-1:0] stat_word;

   always_comb begin
      addr_sel = SEL_NONE;
      if (reg_addr == AW'(REG_WIPER))   addr_sel = SEL_WIPER;
      else if (reg_addr == AW'(REG_GP)) addr_sel = SEL_GP;
   end
   assign is_stat = (reg_addr == AW'(REG_STAT));

   assign bus_ok = pwr_good && recall_done && !busy;

   nvr_recall #(.RECALL_CYC(RECALL_CYC)) u_recall (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .done     (recall_done),
      .fire     (recall_fire)
   );

   nvr_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .bus_ok   (bus_ok),
      .wr_stb   (wr_stb),
      .is_stat  (is_stat),
      .wel_in   (wr_data[WEL_BIT]),
      .wel      (wel_q)
   );

   nvr_wcycle #(.DW(DW), .WR_CYCLES(WR_CYCLES)) u_wcycle (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwr_good    (pwr_good),
      .bus_ok      (bus_ok),
      .wr_stb      (wr_stb),
      .cmd_stop    (cmd_stop),
      .wel         (wel_q),
      .sel         (addr_sel),
      .wr_data     (wr_data),
      .busy        (busy),
      .commit      (commit),
      .commit_sel  (commit_sel),
      .commit_data (commit_data)
   );

   // Shadow storage: loaded only by the first reset, kept across power loss
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_wip_q <= DW'(NV_WIPER_INIT);
         nv_gp_q  <= DW'(NV_GP_INIT);
      end else if (commit) begin
         if (commit_sel == SEL_WIPER) nv_wip_q <= commit_data;
         if (commit_sel == SEL_GP)    nv_gp_q  <= commit_data;
      end
   end

   assign nv_wip_nxt = (commit && commit_sel == SEL_WIPER) ? commit_data : nv_wip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wiper_q <= MIDSCALE;
      else if (pwr_good && !brown_out && (recall_done || recall_fire))
         wiper_q <= nv_wip_nxt;
      else
         wiper_q <= MIDSCALE;
   end
   assign wiper = wiper_q;

   always_comb begin
      stat_word          = '0;
      stat_word[WEL_BIT] = wel_q;
      case (addr_sel)
         SEL_WIPER: rd_raw = nv_wip_q;
         SEL_GP:    rd_raw = nv_gp_q;
         default:   rd_raw = is_stat ? stat_word : '0;
      endcase
   end

   generate
      if (BUSY_RD_ZERO) begin : g_rd_mask
         assign rd_data = busy ? '0 : rd_raw;
      end else begin : g_rd_open
         assign rd_data = rd_raw;
      end
   endgenerate
endmodule

// File: rtl/nvr_ctrl_chk.sv
module nvr_ctrl_chk #(
   parameter int unsigned DW        = 8,
   parameter int unsigned AW        = 3,
   parameter int unsigned WEL_BIT   = 3,
   parameter int unsigned WR_CYCLES = 2_500_000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pwr_good,
   input logic          brown_out,
   input logic [AW-1:0] reg_addr,
   input logic          wr_stb,
   input logic          busy,
   input logic [DW-1:0] rd_data,
   input logic [DW-1:0] wiper,
   input logic          wel,
   input logic [DW-1:0] nv_wip,
   input logic [DW-1:0] nv_gp
);
   localparam logic [DW-1:0] MID  = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] MASK = DW'(1) << WEL_BIT;

   int unsigned busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R4
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && $past(pwr_good) |-> busy_run == WR_CYCLES);

   // R9
   brownout_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brown_out |=> wiper == MID);

   // R10
   pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (wiper == MID) && !busy);

   // R3
   nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(nv_wip) && $stable(nv_gp));

   // R2
   stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == AW'(nvr_pkg::REG_STAT) |-> (rd_data & ~MASK) == '0);

   // R6
   busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_stb && pwr_good |=> $stable(wel));
endmodule

bind nvr_ctrl nvr_ctrl_chk #(
   .DW(DW), .AW(AW), .WEL_BIT(WEL_BIT), .WR_CYCLES(WR_CYCLES)
) u_nvr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_good  (pwr_good),
   .brown_out (brown_out),
   .reg_addr  (reg_addr),
   .wr_stb    (wr_stb),
   .busy      (busy),
   .rd_data   (rd_data),
   .wiper     (wiper),
   .wel       (wel_q),
   .nv_wip    (nv_wip_q),
   .nv_gp     (nv_gp_q)
);

// File: tb/nvr_ctrl_bench.sv
`timescale 1ns/1ps
module nvr_ctrl_bench;
   localparam int unsigned WR  = 20;
   localparam int unsigned RC  = 8;
   localparam logic [7:0]  MID = 8'h80;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_good = 1'b1;
   logic       brown_out = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wr_stb = 1'b0;
   logic       cmd_stop = 1'b0;
   logic [7:0] rd_data;
   logic       busy;
   logic [7:0] wiper;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [7:0] exp_wip = 8'h3C;
   logic [7:0] exp_gp  = 8'hA5;

   always #2 clk = ~clk;

   nvr_ctrl #(
      .WR_CYCLES(WR), .RECALL_CYC(RC),
      .NV_WIPER_INIT('h3C), .NV_GP_INIT('hA5)
   ) u_nvr_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .brown_out(brown_out),
      .reg_addr(reg_addr), .wr_data(wr_data), .wr_stb(wr_stb),
      .cmd_stop(cmd_stop), .rd_data(rd_data), .busy(busy), .wiper(wiper)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; wr_data = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic stop();
      @(negedge clk);
      cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = rd_data;
   endtask

   // returns at the first falling edge with busy low
   task automatic busy_len(output int n);
      n = 0;
      while (busy && n < WR + 10) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 wiper in reset", wiper, MID);
      chk("R1 busy in reset", {7'd0, busy}, 8'h00);
      rst_n = 1'b1;
      rd(3'd7, d);
      chk("R1 status after reset", d, 8'h00);
      repeat (RC - 1) @(negedge clk);
      chk("R8 wiper before recall", wiper, MID);
      @(negedge clk);
      chk("R8 wiper recalled", wiper, exp_wip);
   endtask

   task automatic t_status();
      logic [7:0] d;
      wr(3'd7, 8'hFF);
      rd(3'd7, d);
      chk("R2 status only bit 3", d, 8'h08);
      wr(3'd7, 8'hF7);
      rd(3'd7, d);
      chk("R2 status cleared", d, 8'h00);
   endtask

   task automatic t_blocked();
      logic [7:0] d;
      wr(3'd0, 8'h55);
      stop();
      chk("R3 no busy when blocked", {7'd0, busy}, 8'h00);
      rd(3'd0, d);
      chk("R3 wiper reg unchanged", d, exp_wip);
      chk("R3 wiper output unchanged", wiper, exp_wip);
   endtask

   task automatic t_accept();
      logic [7:0] d;
      int n;
      wr(3'd7, 8'h08);
      wr(3'd0, 8'hC3);
      chk("R4 no busy before stop", {7'd0, busy}, 8'h00);
      stop();
      chk("R4 busy after stop", {7'd0, busy}, 8'h01);
      busy_len(n);
      chk("R4 busy length", 8'(n), 8'(WR));
      exp_wip = 8'hC3;
      rd(3'd0, d);
      chk("R5 wiper reg committed", d, exp_wip);
      chk("R5 wiper output committed", wiper, exp_wip);
      rd(3'd7, d);
      chk("R2 write enable kept after cycle", d, 8'h08);
   endtask

   task automatic t_busy_lock();
      logic [7:0] d;
      int n;
      wr(3'd1, 8'h5A);
      stop();
      rd(3'd1, d);
      chk("R6 read zero while busy", d, 8'h00);
      wr(3'd7, 8'h00);
      wr(3'd1, 8'h11);
      stop();
      busy_len(n);
      exp_gp = 8'h5A;
      rd(3'd1, d);
      chk("R6 spare keeps first value", d, exp_gp);
      rd(3'd7, d);
      chk("R6 status write ignored while busy", d, 8'h08);
      stop();
      chk("R7 stop without pending write", {7'd0, busy}, 8'h00);
   endtask

   task automatic t_last_wins();
      logic [7:0] d;
      int n;
      wr(3'd1, 8'h01);
      wr(3'd1, 8'h02);
      stop();
      busy_len(n);
      exp_gp = 8'h02;
      rd(3'd1, d);
      chk("R7 last write committed", d, exp_gp);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      wr(3'd3, 8'hEE);
      stop();
      chk("R11 no busy for unmapped", {7'd0, busy}, 8'h00);
      rd(3'd3, d);
      chk("R11 unmapped reads zero", d, 8'h00);
   endtask

   task automatic t_brownout();
      logic [7:0] d;
      int n;
      @(negedge clk);
      brown_out = 1'b1;
      @(negedge clk);
      chk("R9 midscale in brownout", wiper, MID);
      wr(3'd0, 8'h77);
      stop();
      busy_len(n);
      exp_wip = 8'h77;
      rd(3'd0, d);
      chk("R9 stored updated in brownout", d, exp_wip);
      chk("R9 output held in brownout", wiper, MID);
      brown_out = 1'b0;
      @(negedge clk);
      chk("R9 reload after brownout", wiper, exp_wip);
   endtask

   task automatic t_power();
      logic [7:0] d;
      wr(3'd1, 8'h99);
      stop();
      repeat (3) @(negedge clk);
      pwr_good = 1'b0;
      @(negedge clk);
      chk("R10 busy aborted", {7'd0, busy}, 8'h00);
      chk("R10 wiper midscale", wiper, MID);
      repeat (2) @(negedge clk);
      pwr_good = 1'b1;
      wr(3'd7, 8'h08);
      repeat (RC - 3) @(negedge clk);
      chk("R8 wiper midscale during recall", wiper, MID);
      @(negedge clk);
      chk("R8 wiper recalled after power", wiper, exp_wip);
      rd(3'd7, d);
      chk("R10 write enable cleared", d, 8'h00);
      rd(3'd1, d);
      chk("R10 aborted write not stored", d, exp_gp);
   endtask

   initial begin
      t_reset();
      t_status();
      t_blocked();
      t_accept();
      t_busy_lock();
      t_last_wins();
      t_unmapped();
      t_brownout();
      t_power();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule